// File: doc/BRIEF.md
# USB Endpoint Buffer Descriptor Engine

This block holds the four-byte buffer descriptor of a single USB device endpoint and decides what happens when the serial engine reports a token for that endpoint. The descriptor bytes are, in address order: status, count low byte, buffer address low byte and buffer address high byte. Firmware fills the count and address bytes first. It then writes the status byte with the ownership bit set, and that write hands the descriptor to the engine. The engine answers NAK, ACK or STALL. It says whether payload bytes should be committed to the data buffer and, on completion, writes the result back into the descriptor and returns ownership to firmware.

The status byte has two layouts, selected by the ownership bit (bit 7). When firmware owns the descriptor, bit 6 is the expected data toggle, bit 3 enables toggle checking and bit 2 requests a buffer stall. After a completed transaction, bit 6 holds the packet toggle and bits 5..2 hold the token PID. In both layouts, bits 1..0 carry bits 9..8 of the 10-bit byte count.

Tokens arrive on a valid/ready stream and responses leave on a second valid/ready stream. A token is accepted only in a cycle where `tok_ready` is high. `tok_ready` is high whenever the response slot is empty or is being drained in that same cycle. A response is held unchanged until `rsp_ready` takes it.

Top module: `usb_bd_engine`

## Requirements
- R1: After reset all four descriptor bytes read 0, `rsp_valid`, `xfer_done`, `stall_pulse` and `cpu_blocked` are 0, and `tok_ready` is 1.
- R2: A token accepted while status bit 7 is 0 gets handshake NAK (`rsp_hs` = 1) with `rsp_commit` = 0 and `rsp_len` = 0, and the descriptor is left unchanged.
- R3: While bit 7 and bit 2 are both set, an OUT (`tok_kind` = 0) or IN (`tok_kind` = 1) token gets STALL (`rsp_hs` = 2). `stall_pulse` is high for one cycle and the descriptor, including bit 7, stays unchanged.
- R4: A SETUP token (`tok_kind` = 2) on a stalled, owned descriptor is not stalled. It completes as in R7, which clears both the stall bit and ownership.
- R5: While owned with bit 3 set, an OUT packet whose toggle differs from bit 6 is answered ACK (`rsp_hs` = 0) with `rsp_commit` = 0. No `xfer_done` is raised and the descriptor is unchanged. With the default parameter, SETUP tokens skip this check.
- R6: On a completing OUT or SETUP token, the committed length is the smaller of `tok_count` and the armed count {status[1:0], count byte}. On a completing IN token, it is the armed count.
- R7: On completion the response is ACK with `rsp_commit` = 1. The status byte becomes {0, toggle, PID[3:0], len[9:8]} and the count byte becomes len[7:0]. The toggle is the packet toggle for OUT/SETUP and the old bit 6 for IN. `xfer_done` is high for exactly one cycle.
- R8: CPU writes to the count or address bytes (`cpu_wr_sel` 1, 2, 3) while bit 7 is set are dropped and set `cpu_blocked`. A later accepted status write (`cpu_wr_sel` = 0) clears `cpu_blocked`.
- R9: `tok_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value.
- R10: `rsp_addr` is {address high byte, address low byte} as held at token acceptance, for every handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_sel | input | 2 | Written byte: 0 status, 1 count, 2 address low, 3 address high |
| cpu_wr_data | input | 8 | Write data |
| cpu_rd_sel | input | 2 | Read byte select, same encoding |
| cpu_rd_data | output | 8 | Selected descriptor byte |
| cpu_blocked | output | 1 | A CPU write was dropped because the engine owned the descriptor |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Token can be accepted |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP |
| tok_pid | input | 4 | Token PID to write back |
| tok_toggle | input | 1 | Data toggle of the packet |
| tok_count | input | 10 | Received byte count |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_hs | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| rsp_commit | output | 1 | Payload bytes are to be moved |
| rsp_len | output | 10 | Bytes to move |
| rsp_addr | output | 16 | Buffer start address |
| xfer_done | output | 1 | One-cycle transaction-complete pulse |
| stall_pulse | output | 1 | One-cycle stall-issued pulse |

## Verification
The bench builds the block with its default parameters. In that build, SETUP tokens bypass toggle checking, so a stalled descriptor can always be released by SETUP. The full 10-bit count lets the bench arm counts above 255, which brings in the two count bits in the status byte during both clipping and write-back. Holding `rsp_ready` low with a second token waiting covers the back-pressure path, and a response is held while the descriptor ownership changes underneath it.

// File: rtl/usb_bd_pkg.sv
package usb_bd_pkg;
  localparam int BYTE_W     = 8;
  localparam int CNT_W      = 10;
  localparam int CNT_HI_W   = CNT_W - BYTE_W;
  localparam int PID_W      = 4;
  localparam int DESC_BYTES = 4;
  localparam int SEL_W      = $clog2(DESC_BYTES);
  localparam int ADDR_W     = 2 * BYTE_W;

  // status byte bit positions
  localparam int B_OWN   = 7;
  localparam int B_TOG   = 6;
  localparam int B_SYNC  = 3;
  localparam int B_STALL = 2;

  localparam logic [SEL_W-1:0] SEL_STAT = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CNT  = 2'd1;

  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2,
    TK_RSVD  = 2'd3
  } tok_kind_t;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_t;

  typedef struct packed {
    hs_t               hs;
    logic              commit;
    logic [CNT_W-1:0]  len;
    logic [ADDR_W-1:0] addr;
  } rsp_t;
endpackage

// File: rtl/usb_bd_regs.sv
module usb_bd_regs
  import usb_bd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [SEL_W-1:0]  cpu_wr_sel,
  input  logic [BYTE_W-1:0] cpu_wr_data,
  input  logic [SEL_W-1:0]  cpu_rd_sel,
  output logic [BYTE_W-1:0] cpu_rd_data,
  input  logic              eng_wb_en,
  input  logic [BYTE_W-1:0] eng_wb_status,
  input  logic [BYTE_W-1:0] eng_wb_cnt,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] cnt_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              blocked_q
);
  logic [DESC_BYTES-1:0][BYTE_W-1:0] desc_w;
  logic own;

  assign own = desc_w[SEL_STAT][B_OWN];

  for (genvar b = 0; b < DESC_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] q;
    logic              cpu_hit;
    assign cpu_hit   = cpu_wr_en && (cpu_wr_sel == SEL_W'(b));
    assign desc_w[b] = q;

    if (b == 0) begin : g_stat
      // engine write-back wins over a simultaneous CPU status write
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (eng_wb_en) q <= eng_wb_status;
        else if (cpu_hit)   q <= cpu_wr_data;
      end
    end else if (b == 1) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n)                q <= '0;
        else if (eng_wb_en)        q <= eng_wb_cnt;
        else if (cpu_hit && !own)  q <= cpu_wr_data;
      end
    end else begin : g_addr
      always_ff @(posedge clk) begin
        if (!rst_n)               q <= '0;
        else if (cpu_hit && !own) q <= cpu_wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      blocked_q <= 1'b0;
    else if (cpu_wr_en && cpu_wr_sel != SEL_STAT && own)
      blocked_q <= 1'b1;
    else if (cpu_wr_en && cpu_wr_sel == SEL_STAT && !eng_wb_en)
      blocked_q <= 1'b0;
  end

  assign cpu_rd_data = desc_w[cpu_rd_sel];
  assign stat_q      = desc_w[0];
  assign cnt_q       = desc_w[1];
  assign addr_q      = {desc_w[3], desc_w[2]};

  AST_IDLE_DESC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!own && !cpu_wr_en) |=> $stable(desc_w)); // R2

  AST_OWNED_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (own && !eng_wb_en) |=> $stable(desc_w[3:1])); // R8
endmodule

// File: rtl/usb_bd_decide.sv
module usb_bd_decide
  import usb_bd_pkg::*;
#(
  parameter bit CHECK_SETUP_TOGGLE = 1'b0
) (
  input  logic [1:0]        kind,
  input  logic [PID_W-1:0]  pid,
  input  logic              toggle,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [BYTE_W-1:0] stat,
  input  logic [BYTE_W-1:0] cnt,
  output hs_t               hs,
  output logic              commit,
  output logic [CNT_W-1:0]  len,
  output logic              stall_hit,
  output logic [BYTE_W-1:0] wb_status,
  output logic [BYTE_W-1:0] wb_cnt
);
  logic [CNT_W-1:0] armed;
  logic             is_in, is_setup, sync_applies, tog_bad, wb_tog;

  assign armed    = {stat[CNT_HI_W-1:0], cnt};
  assign is_in    = (kind == TK_IN);
  assign is_setup = (kind == TK_SETUP);

  if (CHECK_SETUP_TOGGLE) begin : g_sync_all
    assign sync_applies = !is_in;
  end else begin : g_sync_out
    assign sync_applies = !is_in && !is_setup;
  end

  assign tog_bad = sync_applies && stat[B_SYNC] && (toggle != stat[B_TOG]);

  always_comb begin
    hs        = HS_NAK;
    commit    = 1'b0;
    len       = '0;
    stall_hit = 1'b0;
    if (stat[B_OWN]) begin
      if (stat[B_STALL] && !is_setup) begin
        hs        = HS_STALL;
        stall_hit = 1'b1;
      end else if (tog_bad) begin
        hs = HS_ACK;
      end else begin
        hs     = HS_ACK;
        commit = 1'b1;
        if (is_in)               len = armed;
        else if (rx_cnt < armed) len = rx_cnt;
        else                     len = armed;
      end
    end
  end

  assign wb_tog    = is_in ? stat[B_TOG] : toggle;
  assign wb_status = {1'b0, wb_tog, pid, len[CNT_W-1:BYTE_W]};
  assign wb_cnt    = len[BYTE_W-1:0];
endmodule

// File: rtl/usb_bd_rsp.sv
module usb_bd_rsp
  import usb_bd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  rsp_t rsp_in,
  input  logic rsp_ready,
  output logic rsp_valid,
  output rsp_t rsp_q,
  output logic can_take
);
  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_q     <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_q     <= rsp_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_q))); // R9
endmodule

// File: rtl/usb_bd_engine.sv
module usb_bd_engine
  import usb_bd_pkg::*;
#(
  parameter bit CHECK_SETUP_TOGGLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [1:0]        cpu_wr_sel,
  input  logic [7:0]        cpu_wr_data,
  input  logic [1:0]        cpu_rd_sel,
  output logic [7:0]        cpu_rd_data,
  output logic              cpu_blocked,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [1:0]        tok_kind,
  input  logic [3:0]        tok_pid,
  input  logic              tok_toggle,
  input  logic [9:0]        tok_count,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_hs,
  output logic              rsp_commit,
  output logic [9:0]        rsp_len,
  output logic [15:0]       rsp_addr,
  output logic              xfer_done,
  output logic              stall_pulse
);
  logic [BYTE_W-1:0] stat_w, cnt_w, wb_status, wb_cnt;
  logic [ADDR_W-1:0] addr_w;
  logic [CNT_W-1:0]  dec_len;
  hs_t               dec_hs;
  logic              dec_commit, dec_stall, accept;
  rsp_t              rsp_next, rsp_q;

  assign accept = tok_valid && tok_ready;

  usb_bd_regs i_regs (
    .clk, .rst_n,
    .cpu_wr_en, .cpu_wr_sel, .cpu_wr_data, .cpu_rd_sel, .cpu_rd_data,
    .eng_wb_en     (accept && dec_commit),
    .eng_wb_status (wb_status),
    .eng_wb_cnt    (wb_cnt),
    .stat_q        (stat_w),
    .cnt_q         (cnt_w),
    .addr_q        (addr_w),
    .blocked_q     (cpu_blocked)
  );

  usb_bd_decide #(.CHECK_SETUP_TOGGLE(CHECK_SETUP_TOGGLE)) i_decide (
    .kind      (tok_kind),
    .pid       (tok_pid),
    .toggle    (tok_toggle),
    .rx_cnt    (tok_count),
    .stat      (stat_w),
    .cnt       (cnt_w),
    .hs        (dec_hs),
    .commit    (dec_commit),
    .len       (dec_len),
    .stall_hit (dec_stall),
    .wb_status (wb_status),
    .wb_cnt    (wb_cnt)
  );

  assign rsp_next = '{hs: dec_hs, commit: dec_commit, len: dec_len, addr: addr_w};

  usb_bd_rsp i_rsp (
    .clk, .rst_n,
    .load      (accept),
    .rsp_in    (rsp_next),
    .rsp_ready,
    .rsp_valid,
    .rsp_q,
    .can_take  (tok_ready)
  );

  assign rsp_hs     = rsp_q.hs;
  assign rsp_commit = rsp_q.commit;
  assign rsp_len    = rsp_q.len;
  assign rsp_addr   = rsp_q.addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_done   <= 1'b0;
      stall_pulse <= 1'b0;
    end else begin
      xfer_done   <= accept && dec_commit;
      stall_pulse <= accept && dec_stall;
    end
  end

  AST_DONE_RELEASES_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !stat_w[B_OWN]); // R7

  AST_DONE_COUNT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> ({stat_w[CNT_HI_W-1:0], cnt_w} == rsp_len && rsp_commit)); // R6

  AST_STALL_KEEPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_pulse && $past(!(cpu_wr_en && cpu_wr_sel == SEL_STAT)))
      |-> (stat_w[B_OWN] && stat_w[B_STALL])); // R3

  AST_NAK_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hs == HS_NAK) |-> (!rsp_commit && rsp_len == '0)); // R2

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_done, stall_pulse})); // R7
endmodule

// File: tb/test_usb_bd_engine.sv
`timescale 1ns/1ps
module test_usb_bd_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr_en = 1'b0;
  logic [1:0] cpu_wr_sel = '0, cpu_rd_sel = '0;
  logic [7:0] cpu_wr_data = '0, cpu_rd_data;
  logic cpu_blocked, tok_valid = 1'b0, tok_ready, tok_toggle = 1'b0;
  logic [1:0] tok_kind = '0, rsp_hs;
  logic [3:0] tok_pid = '0;
  logic [9:0] tok_count = '0, rsp_len;
  logic rsp_valid, rsp_ready = 1'b1, rsp_commit, xfer_done, stall_pulse;
  logic [15:0] rsp_addr;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  usb_bd_engine i_usb_bd_engine (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference state
  int m_st, m_cnt, m_alo, m_ahi, m_hs, m_len, m_addr;
  bit m_blk, m_rv, m_cm, m_done, m_stp;

  function automatic int m_byte(input int s);
    case (s)
      0: return m_st;
      1: return m_cnt;
      2: return m_alo;
      default: return m_ahi;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit rdy, acc, own, wb, cm, tg;
    int armed, ln, hs, nst, ncnt;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_alo = 0; m_ahi = 0; m_blk = 0;
      m_rv = 0; m_hs = 0; m_len = 0; m_addr = 0; m_cm = 0;
      m_done = 0; m_stp = 0;
    end else begin
      rdy = !m_rv || rsp_ready;
      acc = tok_valid && rdy;
      own = m_st[7];
      wb = 0; nst = 0; ncnt = 0;
      m_done = 0; m_stp = 0;
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc) begin
        armed = ((m_st & 3) << 8) | m_cnt;
        hs = 1; cm = 0; ln = 0;
        if (!own) hs = 1;
        else if (m_st[2] && tok_kind != 2) begin hs = 2; m_stp = 1; end
        else if (m_st[3] && tok_kind == 0 && tok_toggle != m_st[6]) hs = 0;
        else begin
          hs = 0; cm = 1;
          if (tok_kind == 1) ln = armed;
          else ln = (int'(tok_count) < armed) ? int'(tok_count) : armed;
        end
        m_rv = 1; m_hs = hs; m_cm = cm; m_len = ln;
        m_addr = (m_ahi << 8) | m_alo;
        m_done = cm;
        if (cm) begin
          tg = (tok_kind == 1) ? m_st[6] : tok_toggle;
          nst = (int'(tg) << 6) | (int'(tok_pid) << 2) | (ln >> 8);
          ncnt = ln & 8'hFF;
          wb = 1;
        end
      end
      if (cpu_wr_en) begin
        if (cpu_wr_sel == 0) begin
          if (!wb) begin m_st = cpu_wr_data; m_blk = 0; end
        end else if (own) m_blk = 1;
        else if (cpu_wr_sel == 1) m_cnt = cpu_wr_data;
        else if (cpu_wr_sel == 2) m_alo = cpu_wr_data;
        else m_ahi = cpu_wr_data;
      end
      if (wb) begin m_st = nst; m_cnt = ncnt; end
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 rsp_valid", rsp_valid, m_rv);
      chk("R9 tok_ready", tok_ready, !m_rv || rsp_ready);
      if (m_rv) begin
        chk("R2 rsp_hs", rsp_hs, m_hs);
        chk("R5 rsp_commit", rsp_commit, m_cm);
        chk("R6 rsp_len", rsp_len, m_len);
        chk("R10 rsp_addr", rsp_addr, m_addr);
      end
      chk("R7 xfer_done", xfer_done, m_done);
      chk("R3 stall_pulse", stall_pulse, m_stp);
      chk("R8 cpu_blocked", cpu_blocked, m_blk);
      chk("R7 cpu_rd_data", cpu_rd_data, m_byte(cpu_rd_sel));
    end
  end

  task automatic cpu_write(input int sel, input int data);
    @(negedge clk); #1;
    cpu_wr_en = 1'b1; cpu_wr_sel = 2'(sel); cpu_wr_data = 8'(data);
    @(negedge clk); #1;
    cpu_wr_en = 1'b0;
  endtask

  task automatic send_tok(input int kind, input int pid, input bit tog, input int cnt);
    @(negedge clk); #1;
    tok_valid = 1'b1; tok_kind = 2'(kind); tok_pid = 4'(pid);
    tok_toggle = tog; tok_count = 10'(cnt);
    @(negedge clk); #1;
    tok_valid = 1'b0;
  endtask

  task automatic peek(input string tag, input int sel, input int exp);
    cpu_rd_sel = 2'(sel); #1;
    chk(tag, cpu_rd_data, exp);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    for (int s = 0; s < 4; s++) peek("R1 reset byte", s, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 tok_ready", tok_ready, 1);
    chk("R1 flags", {xfer_done, stall_pulse, cpu_blocked}, 0);

    // R2 token while firmware owns the descriptor
    send_tok(0, 1, 0, 5);
    chk("R2 nak", rsp_hs, 1);
    chk("R2 no commit", rsp_commit, 0);
    peek("R2 status untouched", 0, 0);

    // arm and complete an OUT transfer
    cpu_write(1, 8'h40); cpu_write(2, 8'h80); cpu_write(3, 8'h20);
    cpu_write(0, 8'h88);
    send_tok(0, 1, 0, 8'h20);
    chk("R7 ack", rsp_hs, 0);
    chk("R7 commit", rsp_commit, 1);
    chk("R6 short len", rsp_len, 10'h20);
    chk("R10 addr", rsp_addr, 16'h2080);
    chk("R7 done", xfer_done, 1);
    peek("R7 status wb", 0, 8'h04);
    peek("R7 count wb", 1, 8'h20);

    // R5 toggle mismatch: acked, dropped
    cpu_write(1, 8'h40); cpu_write(0, 8'hC8);
    send_tok(0, 1, 0, 8'h10);
    chk("R5 ack", rsp_hs, 0);
    chk("R5 no commit", rsp_commit, 0);
    chk("R5 no done", xfer_done, 0);
    peek("R5 status kept", 0, 8'hC8);

    // R6 clip to armed count
    send_tok(0, 1, 1, 10'h3FF);
    chk("R6 clipped", rsp_len, 10'h40);
    peek("R7 status toggle", 0, 8'h44);

    // R6 IN uses armed count with high bits
    cpu_write(1, 8'h05); cpu_write(0, 8'h83);
    send_tok(1, 9, 1, 0);
    chk("R6 in len", rsp_len, 10'h305);
    peek("R7 status hi bits", 0, 8'h27);
    peek("R7 count low", 1, 8'h05);

    // R3 stall
    cpu_write(0, 8'h84);
    send_tok(0, 1, 0, 3);
    chk("R3 stall hs", rsp_hs, 2);
    chk("R3 stall pulse", stall_pulse, 1);
    peek("R3 status kept", 0, 8'h84);
    send_tok(1, 9, 0, 0);
    chk("R3 stall in", rsp_hs, 2);

    // R8 blocked write
    cpu_write(1, 8'h99);
    chk("R8 blocked", cpu_blocked, 1);
    peek("R8 count kept", 1, 8'h05);

    // R4 SETUP releases stall
    send_tok(2, 4'hD, 1, 8);
    chk("R4 setup ack", rsp_hs, 0);
    chk("R4 setup len", rsp_len, 5);
    peek("R4 status released", 0, 8'h74);
    chk("R8 still blocked", cpu_blocked, 1);
    cpu_write(0, 8'h00);
    chk("R8 cleared", cpu_blocked, 0);

    // R9 back-pressure
    cpu_write(1, 8'h10); cpu_write(0, 8'h80);
    @(negedge clk); #1 rsp_ready = 1'b0;
    send_tok(0, 1, 0, 4);
    chk("R9 held valid", rsp_valid, 1);
    chk("R9 not ready", tok_ready, 0);
    tok_valid = 1'b1; tok_kind = 2'd1;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 len held", rsp_len, 4);
    rsp_ready = 1'b1;
    @(negedge clk); #1;
    tok_valid = 1'b0;
    chk("R2 nak after release", rsp_hs, 1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule